// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block decides whether a processor should take an interrupt at the next instruction boundary, and at which priority. Seven active-low request lines carry priorities 1 (lowest) to 7 (highest). A line counts only after two consecutive samples see it low. Lines 1 to 6 are level requests, and the 3-bit priority mask blocks them. Line 7 cannot be masked. It is edge-qualified, so it raises a request once for each new assertion, and again when the mask is lowered from 7 while the line is still held.

The block reports a pending flag and the binary level of the highest eligible request. The levels of lines 1 to 6 are not latched: a line that is withdrawn before the boundary simply vanishes. When the core presents its instruction-boundary strobe while a request is pending, the block pulses `take` in the same cycle. At the next edge the mask register loads the serviced level. The core can also rewrite the mask, for example when it returns from a handler.

Lines are sampled on every rising edge of `clk`. To sample on the falling edges of the system clock, connect the inverted system clock to `clk`. All interfaces are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `intr_priority_gate`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `mask` is 7, and `pending` and `take` are 0.
- R2: A line is valid only once it has been seen low on two consecutive samples. A low applied before edge k makes the line count from just after edge k+1. A line that is low for only one sample never produces a request.
- R3: Requests on lines 1 to 6 are not held. One edge after a line returns high, it no longer contributes to `pending` or `level`.
- R4: A line i from 1 to 6 (bit i-1 of `irq_n`) is eligible only when i is strictly greater than `mask`. A mask of 0 blocks none of them.
- R5: `pending` is 1 when any request is eligible. `level` is then the binary number (1 to 7) of the highest eligible request, so a newly arriving higher request replaces a lower one that is waiting.
- R6: Line 7 (bit 6 of `irq_n`) ignores the mask. Each new valid assertion makes one request, visible as soon as the line is valid. After that request is taken, keeping the line low raises no further request.
- R7: When `mask_load` changes the mask from 7 to a lower value while line 7 is valid, a new level-7 request is pending from the next cycle. Writing 7 over 7 raises none.
- R8: Once raised, a level-7 request stays pending until it is taken, even if line 7 returns high.
- R9: `take` is 1 exactly in a cycle where `boundary` is 1 and `pending` is 1. When nothing is pending, `boundary` has no effect on `take` or `mask`.
- R10: After a cycle with `take` set, `mask` equals the `level` of that cycle. A `mask_load` in the same cycle is ignored.
- R11: In a cycle without `take`, `mask_load` writes `mask_load_val` into the mask at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 7 | Request lines, active low; bit i-1 is priority i |
| mask_load | input | 1 | Write the priority mask from `mask_load_val` |
| mask_load_val | input | 3 | New mask value |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| pending | output | 1 | An eligible request exists |
| level | output | 3 | Priority of the highest eligible request |
| take | output | 1 | Interrupt taken this cycle |
| mask | output | 3 | Current priority mask |

## Verification
The bench sweeps every mask value against every combination of lines 1 to 6, then takes each result at a boundary. A comparison that was off by one at the mask boundary, or an inverted priority encoder, would report the wrong level or take at a blocked level. Directed runs hold line 7 low across a take, a 7-to-lower mask write and a 7-to-7 rewrite. A level-sensitive line 7 would re-request endlessly. A missing mask-drop path would never re-request. A flag without a hold would lose a line-7 request released before the boundary. Further checks cover the following: a one-sample glitch must stay invisible, a withdrawn low-priority line must drop out, and a mask write that meets a take in the same cycle must lose.

// File: rtl/intr_pkg.sv
package intr_pkg;
  // Defaults shared by the recognizer and its submodules.
  localparam int unsigned DEF_LINES   = 7;
  localparam int unsigned DEF_SAMPLES = 2;

  // Bits needed to carry a level number 0..lines.
  function automatic int unsigned lvl_width(input int unsigned lines);
    return $clog2(lines + 1);
  endfunction
endpackage

// File: rtl/line_qualifier.sv
// Per-line sampling history; a line qualifies once SAMPLES successive
// samples have all seen it asserted (low).
module line_qualifier #(
  parameter int unsigned LINES   = intr_pkg::DEF_LINES,
  parameter int unsigned SAMPLES = intr_pkg::DEF_SAMPLES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_n,
  output logic [LINES-1:0] qual
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SAMPLES-1:0] hist;

    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= {hist[SAMPLES-2:0], ~line_n[g]};
    end

    assign qual[g] = &hist;

    if (SAMPLES == 2) begin : g_chk
      // R2: a qualified line was low on both of the last two samples
      assert_two_samples_R2: assert property (@(posedge clk) disable iff (rst)
        qual[g] |-> ($past(!line_n[g], 1) && $past(!line_n[g], 2)));
    end
  end
endmodule

// File: rtl/nmi_tracker.sv
// Edge-qualified top-level request: one request per new assertion or per
// mask drop from the top value while the line is held.
module nmi_tracker (
  input  logic clk,
  input  logic rst,
  input  logic qual_top,      // qualified top line
  input  logic drop_from_top, // mask being lowered from the top value
  input  logic take_top,      // top level taken this cycle
  output logic nmi_req
);
  logic qual_d;
  logic flag;
  logic rise;

  assign rise    = qual_top & ~qual_d;
  assign nmi_req = flag | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d <= 1'b0;
      flag   <= 1'b0;
    end else begin
      qual_d <= qual_top;
      if (take_top) flag <= 1'b0;
      else          flag <= flag | rise | (drop_from_top & qual_top);
    end
  end

  // R8: an untaken top request is never dropped
  assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !take_top) |=> nmi_req);

  // R7: lowering the mask from the top with the line held raises a request
  assert_retrigger_on_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (drop_from_top && qual_top) |=> nmi_req);

  // R6: taking while the line is held leaves nothing behind
  assert_no_rerequest_held_R6: assert property (@(posedge clk) disable iff (rst)
    (take_top && qual_top) |=> !nmi_req);
endmodule

// File: rtl/level_arbiter.sv
// Priority encoder: binary number of the highest eligible request.
module level_arbiter #(
  parameter int unsigned LINES = intr_pkg::DEF_LINES,
  parameter int unsigned LVL_W = intr_pkg::lvl_width(LINES)
) (
  input  logic [LINES-1:0] eligible,
  output logic             any,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < LINES; i++) begin
      if (eligible[i]) level = LVL_W'(i + 1);
    end
  end

  assign any = |eligible;
endmodule

// File: rtl/mask_register.sv
// Priority mask: loaded with the serviced level on take, else by the core.
module mask_register #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned TOP   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [LVL_W-1:0] take_lvl,
  input  logic             load,
  input  logic [LVL_W-1:0] load_val,
  output logic [LVL_W-1:0] mask,
  output logic             drop_from_top
);
  localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP);

  assign drop_from_top = load && !take && (mask == TOP_V) && (load_val != TOP_V);

  always_ff @(posedge clk) begin
    if (rst)       mask <= TOP_V;
    else if (take) mask <= take_lvl;
    else if (load) mask <= load_val;
  end

  // R11: an uncontested write lands in the mask
  assert_load_lands_R11: assert property (@(posedge clk) disable iff (rst)
    (load && !take) |=> (mask == $past(load_val)));
endmodule

// File: rtl/intr_priority_gate.sv
// Interrupt request recognizer: qualification, masking, top-level edge
// tracking, arbitration and mask update on take.
module intr_priority_gate #(
  parameter int unsigned LINES   = intr_pkg::DEF_LINES,
  parameter int unsigned SAMPLES = intr_pkg::DEF_SAMPLES,
  parameter int unsigned LVL_W   = intr_pkg::lvl_width(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_n,
  input  logic             mask_load,
  input  logic [LVL_W-1:0] mask_load_val,
  input  logic             boundary,
  output logic             pending,
  output logic [LVL_W-1:0] level,
  output logic             take,
  output logic [LVL_W-1:0] mask
);
  localparam logic [LVL_W-1:0] TOP_V = LVL_W'(LINES);

  logic [LINES-1:0] qual;
  logic [LINES-1:0] eligible;
  logic             nmi_req;
  logic             drop_from_top;
  logic             take_top;

  line_qualifier #(.LINES(LINES), .SAMPLES(SAMPLES)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .line_n (irq_n),
    .qual   (qual)
  );

  // Maskable lines: level strictly above the mask.
  for (genvar g = 0; g < LINES - 1; g++) begin : g_elig
    assign eligible[g] = qual[g] && (LVL_W'(g + 1) > mask);
  end
  assign eligible[LINES-1] = nmi_req;

  level_arbiter #(.LINES(LINES), .LVL_W(LVL_W)) u_arb (
    .eligible (eligible),
    .any      (pending),
    .level    (level)
  );

  assign take     = boundary && pending;
  assign take_top = take && (level == TOP_V);

  nmi_tracker u_nmi (
    .clk           (clk),
    .rst           (rst),
    .qual_top      (qual[LINES-1]),
    .drop_from_top (drop_from_top),
    .take_top      (take_top),
    .nmi_req       (nmi_req)
  );

  mask_register #(.LVL_W(LVL_W), .TOP(LINES)) u_mask (
    .clk           (clk),
    .rst           (rst),
    .take          (take),
    .take_lvl      (level),
    .load          (mask_load),
    .load_val      (mask_load_val),
    .mask          (mask),
    .drop_from_top (drop_from_top)
  );

  // R10: the mask follows the serviced level
  assert_mask_follows_take_R10: assert property (@(posedge clk) disable iff (rst)
    take |=> (mask == $past(level)));

  // R4: a reported maskable level always lies above the mask
  assert_level_above_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (pending && level != TOP_V) |-> (level > mask));

  // R5: the reported level always has a qualified source behind it
  assert_level_sourced_R5: assert property (@(posedge clk) disable iff (rst)
    (pending && level != TOP_V) |-> qual[level - 1]);
endmodule

// File: tb/tb_intr_priority_gate.sv
`timescale 1ns/1ps
module tb_intr_priority_gate;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] irq_n;
  logic       mask_load;
  logic [2:0] mask_load_val;
  logic       boundary;
  logic       pending;
  logic [2:0] level;
  logic       take;
  logic [2:0] mask;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  intr_priority_gate dut (
    .clk           (clk),
    .rst           (rst),
    .irq_n         (irq_n),
    .mask_load     (mask_load),
    .mask_load_val (mask_load_val),
    .boundary      (boundary),
    .pending       (pending),
    .level         (level),
    .take          (take),
    .mask          (mask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_n = '1; mask_load = 1'b0; mask_load_val = '0; boundary = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic load_mask(input int m);
    mask_load = 1'b1; mask_load_val = 3'(m);
    tick();
    mask_load = 1'b0;
  endtask

  // Strobe the boundary for one cycle; check take, then the mask after the edge.
  task automatic strobe(input string tag, input int exp_take, input int exp_mask);
    boundary = 1'b1;
    #1;
    chk({tag, " take R9"}, int'(take), exp_take);
    tick();
    boundary = 1'b0;
    chk({tag, " mask R10"}, int'(mask), exp_mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 mask", int'(mask), 7);
    chk("R1 pending", int'(pending), 0);
    chk("R1 take", int'(take), 0);

    // Sweep: every mask against every pattern of lines 1..6.
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 64; p++) begin
        int exp_lvl;
        irq_n = '1;
        load_mask(m);
        tick();
        chk("R11 load", int'(mask), m);
        irq_n = {1'b1, ~6'(p)};
        tick();
        chk("R2 one sample", int'(pending), 0);
        tick();
        exp_lvl = 0;
        for (int i = 1; i <= 6; i++) begin
          if (((p >> (i - 1)) & 1) != 0 && i > m) exp_lvl = i;
        end
        chk("R4 pending", int'(pending), (exp_lvl != 0) ? 1 : 0);
        if (exp_lvl != 0) chk("R5 level", int'(level), exp_lvl);
        strobe("sweep", (exp_lvl != 0) ? 1 : 0, (exp_lvl != 0) ? exp_lvl : m);
        irq_n = '1;
      end
    end
    tick(); tick();

    // Glitch of one sample on line 3 never qualifies.
    do_reset();
    load_mask(0);
    irq_n[2] = 1'b0;
    tick();
    irq_n[2] = 1'b1;
    tick();
    chk("R2 glitch a", int'(pending), 0);
    tick();
    chk("R2 glitch b", int'(pending), 0);

    // Higher arrival, withdrawal, take beating load.
    irq_n[0] = 1'b0;
    tick(); tick();
    chk("R5 low only", int'(level), 1);
    irq_n[4] = 1'b0;
    tick();
    chk("R5 not yet", int'(level), 1);
    tick();
    chk("R5 higher wins", int'(level), 5);
    irq_n[4] = 1'b1;
    tick();
    chk("R3 withdrawn", int'(level), 1);
    irq_n[0] = 1'b1;
    tick();
    chk("R3 gone", int'(pending), 0);
    irq_n[3] = 1'b0;
    tick(); tick();
    chk("R5 line4", int'(level), 4);
    mask_load = 1'b1; mask_load_val = 3'd6;
    strobe("R10 vs load", 1, 4);
    mask_load = 1'b0;
    load_mask(2);
    chk("R11 lower", int'(mask), 2);
    chk("R4 reopened", int'(level), 4);
    irq_n = '1;
    tick(); tick();

    // Line 7: held low, non-maskable, taken once.
    do_reset();
    irq_n[6] = 1'b0;
    tick();
    chk("R2 line7 one sample", int'(pending), 0);
    tick();
    chk("R6 unmaskable", int'(pending), 1);
    chk("R6 level", int'(level), 7);
    tick(); tick(); tick();
    chk("R8 stays", int'(pending), 1);
    strobe("R6 take7", 1, 7);
    chk("R6 no rerequest a", int'(pending), 0);
    tick(); tick(); tick();
    chk("R6 no rerequest b", int'(pending), 0);

    // Mask drop from 7 while held.
    load_mask(3);
    chk("R7 drop", int'(pending), 1);
    chk("R7 drop level", int'(level), 7);
    strobe("R7 take", 1, 7);
    chk("R7 cleared", int'(pending), 0);
    load_mask(7);
    tick();
    chk("R7 7 to 7", int'(pending), 0);
    load_mask(5);
    chk("R7 drop again", int'(level), 7);
    strobe("R7 take2", 1, 7);

    // Released before take: still pending; fresh assertion re-requests.
    irq_n[6] = 1'b1;
    tick(); tick();
    chk("R6 released idle", int'(pending), 0);
    irq_n[6] = 1'b0;
    tick(); tick();
    chk("R6 new assertion", int'(pending), 1);
    irq_n[6] = 1'b1;
    tick(); tick(); tick();
    chk("R8 after release", int'(pending), 1);
    chk("R8 level", int'(level), 7);
    strobe("R8 take", 1, 7);
    chk("R8 consumed", int'(pending), 0);

    // Lines 6 and 7 together.
    load_mask(0);
    irq_n[5] = 1'b0; irq_n[6] = 1'b0;
    tick(); tick();
    chk("R5 7 over 6", int'(level), 7);
    strobe("R5 take7", 1, 7);
    chk("R4 line6 masked", int'(pending), 0);
    load_mask(5);
    chk("R7 with line6", int'(level), 7);
    strobe("R7 take3", 1, 7);
    load_mask(7);
    irq_n = '1;
    tick();
    chk("R9 idle boundary", int'(pending), 0);
    strobe("R9 idle", 0, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule